// File: doc/BRIEF.md
# Channel Retry and Device-End Controller

This block lets a running channel program retry a failed disc transfer without help from the processor. The disc controller loads a small retry counter through a set-retry function. Each later device-end function raises a device-end condition and a jump condition that the channel can test with a conditional-jump query. While retries remain, the device-end function uses up one count and nothing else happens. Once the count is already zero, the next device-end aborts the channel program and requests an interrupt.

The block owns the program-busy flip-flop and the two transfer-direction flip-flops. It runs a clear-interface sequence when the controller sets an interrupt, when retries run out, or when the channel reports a transfer error or a power-fail warning. That sequence has an effect only while a program is busy. When busy drops, for any reason, the block drops the jump condition and the retry count and raises the interrupt-OK and end-of-data flags toward the controller. Every input is a single-cycle pulse and every response is registered. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `devend_retry_ctrl`

## Requirements
- R1: A `ctl_set_retry` pulse loads the retry counter from the low `RETRY_W` bits of `ctl_data` (4 bits by default). Upper bits of `ctl_data` are ignored.
- R2: A `ctl_dev_end` pulse while the counter is nonzero decrements the counter and sets both the device-end and jump conditions. It produces no `abort_o` and no `int_set_o`.
- R3: A `ctl_dev_end` pulse while the counter is zero runs the interrupt path: one cycle later `int_set_o` pulses, `xfer_err_o` is cleared and the clear-interface sequence runs. A `ctl_set_int` pulse runs the same path.
- R4: The clear-interface sequence acts only while `busy_o` is 1. In that case, on the next cycle `busy_o`, `in_xfer_o` and `out_xfer_o` are 0, `eod_o` is 1 and `abort_o` is high for exactly one cycle. While idle it changes none of these and does not pulse `abort_o`.
- R5: A `chan_set_jump` pulse causes `jump_met_o` to pulse one cycle later only if the jump condition is set. The condition is cleared in either case.
- R6: A `chan_svc_strobe` pulse while device-end is set causes `dev_end_o` and `svc_req_o` to pulse together one cycle later. Device-end stays set after the strobe only if an input or output transfer is active.
- R7: A `chan_xfer_err` or `chan_pwr_warn` pulse sets `xfer_err_o` and runs the clear-interface sequence.
- R8: When `busy_o` falls, whether from `prog_end` or from an abort, the retry counter and the jump condition are cleared and `int_ok_o` and `eod_o` are 1.
- R9: Functions arriving in the same cycle are applied in order: set-retry, then device-end, then set-interrupt. A device-end that arrives with a set-retry judges the newly loaded value.
- R10: `prog_start` while idle sets `busy_o` and clears `int_ok_o`. A transfer start sets its direction flip-flop and clears `eod_o`. The reset state is idle with `int_ok_o` = 1, `eod_o` = 1 and all pulse outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_start | input | 1 | Channel program start pulse |
| prog_end | input | 1 | Channel program normal end pulse |
| in_xfer_start | input | 1 | Input transfer begins |
| in_xfer_stop | input | 1 | Input transfer ends |
| out_xfer_start | input | 1 | Output transfer begins |
| out_xfer_stop | input | 1 | Output transfer ends |
| ctl_set_retry | input | 1 | Controller function: load retry counter |
| ctl_data | input | DATA_W | Controller data bus |
| ctl_dev_end | input | 1 | Controller function: device end |
| ctl_set_int | input | 1 | Controller function: set interrupt |
| chan_svc_strobe | input | 1 | Channel service strobe |
| chan_set_jump | input | 1 | Channel conditional-jump query |
| chan_xfer_err | input | 1 | Channel transfer error |
| chan_pwr_warn | input | 1 | Power-fail warning |
| dev_end_o | output | 1 | Device-end answer to a strobe |
| svc_req_o | output | 1 | Service-request answer to a strobe |
| jump_met_o | output | 1 | Jump condition met answer |
| abort_o | output | 1 | Abort request to the channel |
| int_set_o | output | 1 | Interrupt request set |
| xfer_err_o | output | 1 | Transfer-error flag to the controller |
| eod_o | output | 1 | End-of-data flag |
| int_ok_o | output | 1 | Interrupt-OK flag |
| busy_o | output | 1 | Program busy |
| in_xfer_o | output | 1 | Input transfer active |
| out_xfer_o | output | 1 | Output transfer active |

## Verification
The bench keeps the default `RETRY_W` = 4 and `DATA_W` = 16. At that size every counter load from 0 to 15 can be swept in full. For each load the bench expects exactly that many silent, jump-answering device-ends before the abort, and it puts junk in the upper data bits to show they are ignored. Directed cases then cover the strobe hold rule with and without an active transfer, aborts by error and by power warning, set-interrupt while idle, same-cycle load with device-end, and the counter clear at program end.

// File: rtl/devend_retry_pkg.sv
package devend_retry_pkg;
  localparam int unsigned DEF_RETRY_W = 4;
  localparam int unsigned DEF_DATA_W  = 16;

  typedef struct packed {
    logic busy;
    logic in_x;
    logic out_x;
  } prog_st_t;
endpackage

// File: rtl/dr_retry_count.sv
module dr_retry_count #(
  parameter int unsigned RETRY_W = 4,
  parameter int unsigned DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_retry,
  input  logic [DATA_W-1:0] data,
  input  logic              dev_end,
  input  logic              clear,
  output logic              exhaust
);
  localparam logic [RETRY_W-1:0] ZERO = '0;
  localparam logic [RETRY_W-1:0] ONE  = RETRY_W'(1);

  logic [RETRY_W-1:0] cnt_q, eff, cnt_d;

  // set-retry is applied before device-end: device-end sees the loaded value
  always_comb begin
    eff     = set_retry ? data[RETRY_W-1:0] : cnt_q;
    exhaust = dev_end && (eff == ZERO);
    cnt_d   = eff;
    if (dev_end && (eff != ZERO)) cnt_d = eff - ONE;
    if (clear) cnt_d = ZERO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= ZERO;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_end && !set_retry && !clear && cnt_q != ZERO) |=> (cnt_q == $past(cnt_q) - ONE)); // R2
  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == ZERO)); // R8
  AST_NO_EXHAUST_IF_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    (set_retry && data[RETRY_W-1:0] != ZERO) |-> !exhaust); // R9
endmodule

// File: rtl/dr_jump_track.sv
module dr_jump_track (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_end_fn,
  input  logic set_jump,
  input  logic svc_strobe,
  input  logic xfer_active,
  input  logic busy_drop,
  output logic jump_met_o,
  output logic dev_end_o,
  output logic svc_req_o
);
  logic jump_q, devend_q;
  logic jump_d, devend_d;

  always_comb begin
    jump_d = jump_q;
    if (set_jump)   jump_d = 1'b0;
    if (dev_end_fn) jump_d = 1'b1;
    if (busy_drop)  jump_d = 1'b0;

    devend_d = devend_q;
    if (svc_strobe && devend_q) devend_d = xfer_active;
    if (dev_end_fn) devend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      jump_q     <= 1'b0;
      devend_q   <= 1'b0;
      jump_met_o <= 1'b0;
      dev_end_o  <= 1'b0;
      svc_req_o  <= 1'b0;
    end else begin
      jump_q     <= jump_d;
      devend_q   <= devend_d;
      jump_met_o <= set_jump && jump_q;
      dev_end_o  <= svc_strobe && devend_q;
      svc_req_o  <= svc_strobe && devend_q;
    end
  end

  AST_JUMP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (set_jump && !dev_end_fn) |=> !jump_q); // R5
  AST_DEVEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_strobe && devend_q && xfer_active) |=> devend_q); // R6
  AST_DEVEND_SETS_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_end_fn && !busy_drop) |=> (jump_q && devend_q)); // R2
endmodule

// File: rtl/dr_prog_state.sv
module dr_prog_state
  import devend_retry_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic prog_start,
  input  logic prog_end,
  input  logic in_start,
  input  logic in_stop,
  input  logic out_start,
  input  logic out_stop,
  input  logic int_path,
  input  logic chan_err,
  output logic busy_drop,
  output logic busy_o,
  output logic in_xfer_o,
  output logic out_xfer_o,
  output logic abort_o,
  output logic int_set_o,
  output logic xfer_err_o,
  output logic eod_o,
  output logic int_ok_o
);
  prog_st_t st_q, st_d;
  logic clr_act;
  logic eod_q, eod_d, intok_q, intok_d, xerr_q, xerr_d;

  always_comb begin
    clr_act   = st_q.busy && (int_path || chan_err);
    busy_drop = st_q.busy && (prog_end || clr_act);

    st_d = st_q;
    if (prog_start) st_d.busy = 1'b1;
    if (busy_drop)  st_d.busy = 1'b0;
    if (in_stop)    st_d.in_x = 1'b0;
    if (in_start)   st_d.in_x = 1'b1;
    if (out_stop)   st_d.out_x = 1'b0;
    if (out_start)  st_d.out_x = 1'b1;
    if (clr_act) begin
      st_d.in_x  = 1'b0;
      st_d.out_x = 1'b0;
    end

    eod_d = eod_q;
    if (in_start || out_start) eod_d = 1'b0;
    if (clr_act || busy_drop)  eod_d = 1'b1;

    intok_d = intok_q;
    if (prog_start && !st_q.busy) intok_d = 1'b0;
    if (busy_drop) intok_d = 1'b1;

    xerr_d = xerr_q;
    if (int_path) xerr_d = 1'b0;
    if (chan_err) xerr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= '0;
      eod_q     <= 1'b1;
      intok_q   <= 1'b1;
      xerr_q    <= 1'b0;
      abort_o   <= 1'b0;
      int_set_o <= 1'b0;
    end else begin
      st_q      <= st_d;
      eod_q     <= eod_d;
      intok_q   <= intok_d;
      xerr_q    <= xerr_d;
      abort_o   <= clr_act;
      int_set_o <= int_path;
    end
  end

  assign busy_o     = st_q.busy;
  assign in_xfer_o  = st_q.in_x;
  assign out_xfer_o = st_q.out_x;
  assign eod_o      = eod_q;
  assign int_ok_o   = intok_q;
  assign xfer_err_o = xerr_q;

  AST_ABORT_WAS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> $past(st_q.busy)); // R4
  AST_ABORT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (!st_q.busy && !st_q.in_x && !st_q.out_x && eod_q)); // R4
  AST_IDLE_ENTRY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_q.busy) |-> (intok_q && eod_q)); // R8
  AST_ERR_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    chan_err |=> xerr_q); // R7
endmodule

// File: rtl/devend_retry_ctrl.sv
module devend_retry_ctrl
  import devend_retry_pkg::*;
#(
  parameter int unsigned RETRY_W = DEF_RETRY_W,
  parameter int unsigned DATA_W  = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_start,
  input  logic              prog_end,
  input  logic              in_xfer_start,
  input  logic              in_xfer_stop,
  input  logic              out_xfer_start,
  input  logic              out_xfer_stop,
  input  logic              ctl_set_retry,
  input  logic [DATA_W-1:0] ctl_data,
  input  logic              ctl_dev_end,
  input  logic              ctl_set_int,
  input  logic              chan_svc_strobe,
  input  logic              chan_set_jump,
  input  logic              chan_xfer_err,
  input  logic              chan_pwr_warn,
  output logic              dev_end_o,
  output logic              svc_req_o,
  output logic              jump_met_o,
  output logic              abort_o,
  output logic              int_set_o,
  output logic              xfer_err_o,
  output logic              eod_o,
  output logic              int_ok_o,
  output logic              busy_o,
  output logic              in_xfer_o,
  output logic              out_xfer_o
);
  logic exhaust, int_path, chan_err, busy_drop;

  assign int_path = exhaust || ctl_set_int;
  assign chan_err = chan_xfer_err || chan_pwr_warn;

  dr_retry_count #(.RETRY_W(RETRY_W), .DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .set_retry(ctl_set_retry), .data(ctl_data),
    .dev_end(ctl_dev_end), .clear(busy_drop),
    .exhaust(exhaust)
  );

  dr_jump_track u_jump (
    .clk(clk), .rst_n(rst_n),
    .dev_end_fn(ctl_dev_end), .set_jump(chan_set_jump),
    .svc_strobe(chan_svc_strobe), .xfer_active(in_xfer_o || out_xfer_o),
    .busy_drop(busy_drop),
    .jump_met_o(jump_met_o), .dev_end_o(dev_end_o), .svc_req_o(svc_req_o)
  );

  dr_prog_state u_prog (
    .clk(clk), .rst_n(rst_n),
    .prog_start(prog_start), .prog_end(prog_end),
    .in_start(in_xfer_start), .in_stop(in_xfer_stop),
    .out_start(out_xfer_start), .out_stop(out_xfer_stop),
    .int_path(int_path), .chan_err(chan_err),
    .busy_drop(busy_drop),
    .busy_o(busy_o), .in_xfer_o(in_xfer_o), .out_xfer_o(out_xfer_o),
    .abort_o(abort_o), .int_set_o(int_set_o), .xfer_err_o(xfer_err_o),
    .eod_o(eod_o), .int_ok_o(int_ok_o)
  );

  AST_SVC_MATCHES_DEVEND: assert property (@(posedge clk) disable iff (!rst_n)
    dev_end_o |-> svc_req_o); // R6
  AST_SILENT_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_dev_end && !exhaust && !ctl_set_int && !chan_err && !prog_end) |=> !abort_o); // R2
endmodule

// File: tb/devend_retry_ctrl_bench.sv
module devend_retry_ctrl_bench;
  localparam int RW = 4;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0;
  logic prog_start, prog_end, in_xfer_start, in_xfer_stop, out_xfer_start, out_xfer_stop;
  logic ctl_set_retry, ctl_dev_end, ctl_set_int;
  logic [DW-1:0] ctl_data;
  logic chan_svc_strobe, chan_set_jump, chan_xfer_err, chan_pwr_warn;
  logic dev_end_o, svc_req_o, jump_met_o, abort_o, int_set_o, xfer_err_o;
  logic eod_o, int_ok_o, busy_o, in_xfer_o, out_xfer_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  devend_retry_ctrl #(.RETRY_W(RW), .DATA_W(DW)) u_devend_retry_ctrl (.*);

  task automatic clr_in();
    prog_start = 0; prog_end = 0; in_xfer_start = 0; in_xfer_stop = 0;
    out_xfer_start = 0; out_xfer_stop = 0; ctl_set_retry = 0; ctl_dev_end = 0;
    ctl_set_int = 0; ctl_data = '0; chan_svc_strobe = 0; chan_set_jump = 0;
    chan_xfer_err = 0; chan_pwr_warn = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    clr_in();
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    finish_run();
  end

  initial begin
    clr_in();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset busy", busy_o, 0);
    chk("R10 reset int_ok", int_ok_o, 1);
    chk("R10 reset eod", eod_o, 1);
    chk("R10 reset abort", abort_o, 0);
    chk("R10 reset int_set", int_set_o, 0);

    // R1 R2 R3 R5 R6 R8: sweep every counter load
    for (int n = 0; n < 16; n++) begin
      prog_start = 1; tick();
      chk("R10 start busy", busy_o, 1);
      chk("R10 start int_ok", int_ok_o, 0);
      ctl_set_retry = 1; ctl_data = DW'(n) | 16'hA5F0; tick();
      for (int k = 0; k < n; k++) begin
        ctl_dev_end = 1; tick();
        chk("R2 no abort", abort_o, 0);
        chk("R2 no int", int_set_o, 0);
        chk("R2 still busy", busy_o, 1);
        chan_set_jump = 1; tick();
        chk("R5 jump met", jump_met_o, 1);
        chan_set_jump = 1; tick();
        chk("R5 jump cleared", jump_met_o, 0);
      end
      ctl_dev_end = 1; tick();
      chk("R3 abort at zero", abort_o, 1);
      chk("R3 int_set at zero", int_set_o, 1);
      chk("R4 busy dropped", busy_o, 0);
      chk("R3 xfer_err clear", xfer_err_o, 0);
      chk("R8 int_ok", int_ok_o, 1);
      chk("R8 eod", eod_o, 1);
      tick();
      chk("R4 abort one cycle", abort_o, 0);
      chan_set_jump = 1; tick();
      chk("R8 jump cleared on drop", jump_met_o, 0);
      chan_svc_strobe = 1; tick();
      chk("R6 devend answered", dev_end_o, 1);
      chk("R6 svc answered", svc_req_o, 1);
      chan_svc_strobe = 1; tick();
      chk("R6 devend dropped idle", dev_end_o, 0);
    end

    // R6 hold while a transfer is active
    prog_start = 1; tick();
    in_xfer_start = 1; tick();
    chk("R10 eod cleared", eod_o, 0);
    chk("R10 in_xfer", in_xfer_o, 1);
    ctl_set_retry = 1; ctl_data = 16'd3; tick();
    ctl_dev_end = 1; tick();
    chan_svc_strobe = 1; tick();
    chk("R6 devend 1", dev_end_o, 1);
    chan_svc_strobe = 1; tick();
    chk("R6 devend held", dev_end_o, 1);
    in_xfer_stop = 1; tick();
    chan_svc_strobe = 1; tick();
    chk("R6 devend last", dev_end_o, 1);
    chan_svc_strobe = 1; tick();
    chk("R6 devend gone", dev_end_o, 0);
    chk("R6 svc gone", svc_req_o, 0);

    // R7 transfer error aborts
    out_xfer_start = 1; tick();
    chk("R10 out_xfer", out_xfer_o, 1);
    chan_xfer_err = 1; tick();
    chk("R7 abort", abort_o, 1);
    chk("R7 err flag", xfer_err_o, 1);
    chk("R7 out cleared", out_xfer_o, 0);
    chk("R7 busy", busy_o, 0);
    chk("R7 eod", eod_o, 1);
    // R4 idle: power warning does not abort
    chan_pwr_warn = 1; tick();
    chk("R4 idle no abort", abort_o, 0);
    chk("R7 err flag pwr", xfer_err_o, 1);
    // R3 set-interrupt while idle
    ctl_set_int = 1; tick();
    chk("R3 int_set idle", int_set_o, 1);
    chk("R4 idle no abort int", abort_o, 0);
    chk("R3 err cleared", xfer_err_o, 0);
    // R7 power warning while busy
    prog_start = 1; tick();
    chan_pwr_warn = 1; tick();
    chk("R7 pwr abort", abort_o, 1);
    chk("R7 pwr busy", busy_o, 0);
    // R3 set-interrupt while busy
    prog_start = 1; tick();
    ctl_set_int = 1; tick();
    chk("R3 set_int abort", abort_o, 1);
    chk("R3 set_int pulse", int_set_o, 1);

    // R9 same-cycle load and device-end
    prog_start = 1; tick();
    ctl_set_retry = 1; ctl_data = 16'h0010; ctl_dev_end = 1; tick();
    chk("R9 load zero exhausts", abort_o, 1);
    prog_start = 1; tick();
    ctl_set_retry = 1; ctl_data = 16'd1; ctl_dev_end = 1; tick();
    chk("R9 load one silent", abort_o, 0);
    ctl_dev_end = 1; tick();
    chk("R9 then exhaust", abort_o, 1);

    // R8 program end clears counter
    prog_start = 1; tick();
    ctl_set_retry = 1; ctl_data = 16'd5; tick();
    prog_end = 1; tick();
    chk("R8 end busy", busy_o, 0);
    chk("R8 end abort none", abort_o, 0);
    chk("R8 end int_ok", int_ok_o, 1);
    prog_start = 1; tick();
    ctl_dev_end = 1; tick();
    chk("R8 counter cleared", abort_o, 1);
    chk("R1 counter cleared int", int_set_o, 1);

    repeat (2) tick();
    finish_run();
  end
endmodule